// File: doc/BRIEF.md
# Serial Converter Register Bank

This block is the register bank that a host reaches through the serial port of a data converter. The serial front end deframes 16-bit words and hands each one over with a single-cycle strobe. The top two bits of a write word steer its 14 data bits to one of three places: the control register, a test register, or the calibration coefficient chosen by the control register. A fourth header value discards the word.

Reads do not carry an address. A read-source field held in the control register decides which word the serial port sends out. The choices are the latest conversion result, the test register, the selected calibration coefficient, or a status word. The choice stays in force until software writes the control register again.

The control register also holds the start requests for a single conversion and for a calibration. Each request stays high until the converter core reports that the operation has finished, and then clears itself. The interface-mode bit clears after every completed serial read. A control write that puts ones in the reserved bits raises a one-cycle error flag, and its other fields are still applied.

Top module: `sreg_bank`

## Requirements
- R1: Registers change only in a cycle where `frame_valid_i` is high. `frame_i[15:14]` is the address and `frame_i[13:0]` is the data.
- R2: A frame with address 00 changes no register and no output field.
- R3: A frame with address 01 stores `frame_i[13:0]` in the test register. With read source 01, `rd_word_o` is `{2'b00, test}`.
- R4: A frame with address 11 loads the control fields. Bits 9:8 go to `pwr_mode_o`, 7:6 to `rd_sel_o`, bit 5 to `if_mode_o`, bit 4 to `conv_req_o`, bit 3 to `cal_mode_o`, bits 2:1 to `cal_sel_o` and bit 0 to `cal_req_o`.
- R5: The read source is taken from `rd_sel_o` and persists across frames. With read source 00, `rd_word_o` is the conversion result, zero-extended to 16 bits (four leading zeros at the default RES_W of 12).
- R6: With read source 11, `rd_word_o` is the status word. Bit 15 is 0, bit 14 is `busy_i`, bits 13:10 are 0, bits 9:8 are the power mode, bits 7:6 are 11, and bits 5:0 mirror control bits 5:0.
- R7: `conv_req_o` clears in the cycle after `conv_done_i`. If a control write arrives in the same cycle, the write takes precedence.
- R8: `cal_req_o` clears in the cycle after `cal_done_i`. If a control write arrives in the same cycle, the write takes precedence.
- R9: `if_mode_o` clears in the cycle after `read_done_i`. If a control write arrives in the same cycle, the write takes precedence.
- R10: A control write with nonzero bits 13:10 pulses `ctl_err_o` high for exactly the next cycle. The other control fields are still applied.
- R11: A frame with address 10 writes the coefficient indexed by `cal_sel_o` while `cal_req_o` is 0. The frame is discarded while `cal_req_o` is 1. With read source 10, `rd_word_o` is `{2'b00, coefficient[cal_sel_o]}`.
- R12: After reset, all control fields, the test register, every coefficient and `ctl_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 16 | Deframed serial write word |
| frame_valid_i | input | 1 | Single-cycle strobe: `frame_i` is complete |
| read_done_i | input | 1 | A serial read cycle has finished |
| result_i | input | RES_W | Latest conversion result |
| busy_i | input | 1 | Core is converting or calibrating |
| conv_done_i | input | 1 | Conversion finished |
| cal_done_i | input | 1 | Calibration finished |
| rd_word_o | output | 16 | Word for the next serial read |
| pwr_mode_o | output | 2 | Power-management field |
| rd_sel_o | output | 2 | Read-source field |
| if_mode_o | output | 1 | Interface-mode bit |
| conv_req_o | output | 1 | Single-conversion request |
| cal_mode_o | output | 1 | Calibration type: self or system |
| cal_sel_o | output | 2 | Calibration select / coefficient index |
| cal_req_o | output | 1 | Calibration request |
| test_o | output | 14 | Test register contents |
| ctl_err_o | output | 1 | Reserved-bit write error pulse |

## Verification
The bench builds the block with its defaults: a 12-bit result and four coefficient slots indexed by a 2-bit select. These values bring within reach the four leading zeros of a result read and every slot index that the control field can name. With these parameters the bench can move between slots and show that each slot keeps its own value. It also exercises every self-clearing bit, both alone and colliding with a control write in the same cycle.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = FRAME_W - 2;

  typedef enum logic [1:0] {
    ADR_NONE = 2'b00,
    ADR_TEST = 2'b01,
    ADR_CAL  = 2'b10,
    ADR_CTL  = 2'b11
  } addr_e;

  // field order is the bit order of control word bits 9:0
  typedef struct packed {
    logic [1:0] pwr;
    logic [1:0] rd_sel;
    logic       if_mode;
    logic       conv_req;
    logic       cal_mode;
    logic [1:0] cal_sel;
    logic       cal_req;
  } ctl_t;
endpackage

// File: rtl/sreg_ctl.sv
module sreg_ctl
  import sreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              conv_done_i,
  input  logic              cal_done_i,
  input  logic              read_done_i,
  output ctl_t              ctl_o,
  output logic              err_o
);
  ctl_t ctl_q;
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_i && (|wdata_i[DATA_W-1:10]);
      if (wr_i) begin
        ctl_q <= ctl_t'(wdata_i[9:0]);
      end else begin
        if (conv_done_i) ctl_q.conv_req <= 1'b0;
        if (cal_done_i)  ctl_q.cal_req  <= 1'b0;
        if (read_done_i) ctl_q.if_mode  <= 1'b0;
      end
    end
  end

  assign ctl_o = ctl_q;
  assign err_o = err_q;
endmodule

// File: rtl/sreg_cal_bank.sv
module sreg_cal_bank #(
  parameter int SEL_W  = 2,
  parameter int DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int N = 1 << SEL_W;

  logic [DATA_W-1:0] coef_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           coef_q[g] <= '0;
      else if (wr_i && sel_i == SEL_W'(g))   coef_q[g] <= wdata_i;
    end
  end

  assign rdata_o = coef_q[sel_i];
endmodule

// File: rtl/sreg_rd_mux.sv
module sreg_rd_mux
  import sreg_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  ctl_t               ctl_i,
  input  logic [RES_W-1:0]   result_i,
  input  logic [DATA_W-1:0]  test_i,
  input  logic [DATA_W-1:0]  cal_i,
  input  logic               busy_i,
  output logic [FRAME_W-1:0] word_o
);
  logic [FRAME_W-1:0] status;

  always_comb begin
    status       = '0;
    status[14]   = busy_i;
    status[9:8]  = ctl_i.pwr;
    status[7:6]  = 2'b11;
    status[5:0]  = ctl_i[5:0];
  end

  always_comb begin
    unique case (ctl_i.rd_sel)
      2'b00:   word_o = FRAME_W'(result_i);
      2'b01:   word_o = {2'b00, test_i};
      2'b10:   word_o = {2'b00, cal_i};
      default: word_o = status;
    endcase
  end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        frame_i,
  input  logic               frame_valid_i,
  input  logic               read_done_i,
  input  logic [RES_W-1:0]   result_i,
  input  logic               busy_i,
  input  logic               conv_done_i,
  input  logic               cal_done_i,
  output logic [15:0]        rd_word_o,
  output logic [1:0]         pwr_mode_o,
  output logic [1:0]         rd_sel_o,
  output logic               if_mode_o,
  output logic               conv_req_o,
  output logic               cal_mode_o,
  output logic [1:0]         cal_sel_o,
  output logic               cal_req_o,
  output logic [13:0]        test_o,
  output logic               ctl_err_o
);
  localparam int CAL_SEL_W = 2;

  addr_e             addr;
  logic [DATA_W-1:0] wdata;
  logic              wr_ctl, wr_test, wr_cal;
  ctl_t              ctl;
  logic [DATA_W-1:0] test_q, cal_rd;

  assign addr    = addr_e'(frame_i[FRAME_W-1 -: 2]);
  assign wdata   = frame_i[DATA_W-1:0];
  assign wr_ctl  = frame_valid_i && addr == ADR_CTL;
  assign wr_test = frame_valid_i && addr == ADR_TEST;
  // coefficient access is locked while a calibration is pending
  assign wr_cal  = frame_valid_i && addr == ADR_CAL && !ctl.cal_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      test_q <= '0;
    else if (wr_test) test_q <= wdata;
  end

  sreg_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_ctl),
    .wdata_i     (wdata),
    .conv_done_i (conv_done_i),
    .cal_done_i  (cal_done_i),
    .read_done_i (read_done_i),
    .ctl_o       (ctl),
    .err_o       (ctl_err_o)
  );

  sreg_cal_bank #(.SEL_W(CAL_SEL_W), .DATA_W(DATA_W)) u_cal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_cal),
    .sel_i   (ctl.cal_sel),
    .wdata_i (wdata),
    .rdata_o (cal_rd)
  );

  sreg_rd_mux #(.RES_W(RES_W)) u_mux (
    .ctl_i    (ctl),
    .result_i (result_i),
    .test_i   (test_q),
    .cal_i    (cal_rd),
    .busy_i   (busy_i),
    .word_o   (rd_word_o)
  );

  assign pwr_mode_o = ctl.pwr;
  assign rd_sel_o   = ctl.rd_sel;
  assign if_mode_o  = ctl.if_mode;
  assign conv_req_o = ctl.conv_req;
  assign cal_mode_o = ctl.cal_mode;
  assign cal_sel_o  = ctl.cal_sel;
  assign cal_req_o  = ctl.cal_req;
  assign test_o     = test_q;
endmodule

// File: rtl/sreg_bank_chk.sv
module sreg_bank_chk #(
  parameter int RES_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [15:0]      frame_i,
  input logic             frame_valid_i,
  input logic             read_done_i,
  input logic             busy_i,
  input logic             conv_done_i,
  input logic             cal_done_i,
  input logic [15:0]      rd_word_o,
  input logic [1:0]       pwr_mode_o,
  input logic [1:0]       rd_sel_o,
  input logic             if_mode_o,
  input logic             conv_req_o,
  input logic             cal_req_o,
  input logic [13:0]      test_o,
  input logic             ctl_err_o
);
  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> $stable(test_o) && $stable(pwr_mode_o) && $stable(rd_sel_o));

  assert_null_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i && frame_i[15:14] == 2'b00 |=> $stable(test_o) && $stable(rd_sel_o)
      && $stable(pwr_mode_o));

  assert_result_pad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_o == 2'b00 |-> rd_word_o[15:RES_W] == '0);

  assert_status_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_o == 2'b11 |-> rd_word_o[7:6] == 2'b11 && rd_word_o[14] == busy_i
      && rd_word_o[15] == 1'b0);

  assert_conv_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && !frame_valid_i |=> !conv_req_o);

  assert_cal_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_i && !frame_valid_i |=> !cal_req_o);

  assert_mode_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_done_i && !frame_valid_i |=> !if_mode_o);

  assert_rsvd_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i && frame_i[15:14] == 2'b11 && frame_i[13:10] != 4'h0 |=> ctl_err_o);

  assert_err_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_err_o |=> !ctl_err_o || $past(frame_valid_i));
endmodule

bind sreg_bank sreg_bank_chk #(.RES_W(RES_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_i       (frame_i),
  .frame_valid_i (frame_valid_i),
  .read_done_i   (read_done_i),
  .busy_i        (busy_i),
  .conv_done_i   (conv_done_i),
  .cal_done_i    (cal_done_i),
  .rd_word_o     (rd_word_o),
  .pwr_mode_o    (pwr_mode_o),
  .rd_sel_o      (rd_sel_o),
  .if_mode_o     (if_mode_o),
  .conv_req_o    (conv_req_o),
  .cal_req_o     (cal_req_o),
  .test_o        (test_o),
  .ctl_err_o     (ctl_err_o)
);

// File: tb/sim_sreg_bank.sv
`timescale 1ns/1ps
module sim_sreg_bank;
  localparam int RES_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] frame = '0;
  logic frame_valid = 1'b0, read_done = 1'b0, busy = 1'b0;
  logic conv_done = 1'b0, cal_done = 1'b0;
  logic [RES_W-1:0] result = '0;
  logic [15:0] rd_word;
  logic [1:0] pwr_mode, rd_sel, cal_sel;
  logic if_mode, conv_req, cal_mode, cal_req, ctl_err;
  logic [13:0] test_reg;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sreg_bank #(.RES_W(RES_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .frame_valid_i(frame_valid),
    .read_done_i(read_done), .result_i(result), .busy_i(busy),
    .conv_done_i(conv_done), .cal_done_i(cal_done), .rd_word_o(rd_word),
    .pwr_mode_o(pwr_mode), .rd_sel_o(rd_sel), .if_mode_o(if_mode),
    .conv_req_o(conv_req), .cal_mode_o(cal_mode), .cal_sel_o(cal_sel),
    .cal_req_o(cal_req), .test_o(test_reg), .ctl_err_o(ctl_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one frame; returns at the negedge after the capturing edge
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    frame = w; frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 rd_word", rd_word, 32'h0000);
    chk("R12 fields", {pwr_mode, rd_sel, if_mode, conv_req, cal_mode, cal_sel, cal_req}, 0);
    chk("R12 test", test_reg, 0);
    chk("R12 err", ctl_err, 0);
  endtask

  task automatic t_result;
    result = 12'hABC; #1;
    chk("R5 result abc", rd_word, 32'h0ABC);
    result = 12'hFFF; #1;
    chk("R5 result fff", rd_word, 32'h0FFF);
  endtask

  task automatic t_test_reg;
    send(16'h5234);
    chk("R3 test store", test_reg, 14'h1234);
    chk("R5 sel persists", rd_word, 32'h0FFF);
    send(16'hC040);
    chk("R3 test read", rd_word, 32'h1234);
  endtask

  task automatic t_null;
    send(16'h3FFF);
    chk("R2 test kept", test_reg, 14'h1234);
    chk("R2 ctl kept", {pwr_mode, rd_sel}, 4'b0001);
    chk("R2 read kept", rd_word, 32'h1234);
  endtask

  task automatic t_idle;
    @(negedge clk);
    frame = 16'hC300;
    repeat (3) @(negedge clk);
    chk("R1 no strobe", {pwr_mode, rd_sel}, 4'b0001);
    frame = 16'h0000;
  endtask

  task automatic t_ctl_status;
    send(16'hC2EC);
    chk("R4 pwr", pwr_mode, 2'b10);
    chk("R4 rd_sel", rd_sel, 2'b11);
    chk("R4 low", {if_mode, conv_req, cal_mode, cal_sel, cal_req}, 6'b101100);
    busy = 1'b1; #1;
    chk("R6 status busy", rd_word, 32'h42EC);
    busy = 1'b0; #1;
    chk("R6 status idle", rd_word, 32'h02EC);
  endtask

  task automatic t_mode;
    @(negedge clk); read_done = 1'b1;
    @(negedge clk); read_done = 1'b0;
    chk("R9 mode clear", if_mode, 0);
    chk("R9 status", rd_word, 32'h02CC);
    @(negedge clk); frame = 16'hC0E0; frame_valid = 1'b1; read_done = 1'b1;
    @(negedge clk); frame_valid = 1'b0; read_done = 1'b0;
    chk("R9 write wins", if_mode, 1);
  endtask

  task automatic t_cal;
    send(16'hC084);
    send(16'h8155);
    chk("R11 slot2", rd_word, 32'h0155);
    send(16'hC082);
    chk("R11 slot1 empty", rd_word, 32'h0000);
    send(16'hAAAA);
    chk("R11 slot1", rd_word, 32'h2AAA);
    send(16'hC084);
    chk("R11 slot2 kept", rd_word, 32'h0155);
  endtask

  task automatic t_cal_run;
    send(16'hC083);
    chk("R4 cal req", cal_req, 1);
    send(16'h9111);
    chk("R11 locked", rd_word, 32'h2AAA);
    repeat (2) @(negedge clk);
    chk("R8 held", cal_req, 1);
    cal_done = 1'b1; @(negedge clk); cal_done = 1'b0;
    chk("R8 cleared", cal_req, 0);
    chk("R8 sel kept", cal_sel, 2'b01);
  endtask

  task automatic t_conv;
    send(16'hC010);
    repeat (3) @(negedge clk);
    chk("R7 held", conv_req, 1);
    conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
    chk("R7 cleared", conv_req, 0);
    @(negedge clk); frame = 16'hC010; frame_valid = 1'b1; conv_done = 1'b1;
    @(negedge clk); frame_valid = 1'b0; conv_done = 1'b0;
    chk("R7 write wins", conv_req, 1);
    conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
    chk("R7 cleared again", conv_req, 0);
  endtask

  task automatic t_err;
    send(16'hC500);
    chk("R10 flag", ctl_err, 1);
    chk("R10 applied", pwr_mode, 2'b01);
    chk("R5 back to result", rd_word, 32'h0FFF);
    @(negedge clk);
    chk("R10 one cycle", ctl_err, 0);
    send(16'hC100);
    chk("R10 clean write", ctl_err, 0);
  endtask

  initial begin
    #1;
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_result;
    t_test_reg;
    t_null;
    t_idle;
    t_ctl_status;
    t_mode;
    t_cal;
    t_cal_run;
    t_conv;
    t_err;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule